// File: doc/BRIEF.md
# Variable Node Update Unit

This unit performs the variable-side update of a non-binary LDPC decoder over GF(64). Each accepted input carries three things. The first is one check-to-variable message of `N_IN` unsorted (LLR, symbol) couples. The second is the default offset that the check node attaches to symbols it did not list. The third is the variable's compressed channel information: six bit magnitudes, the positions of the three weakest bits, and the hard-decision symbol.

From these the unit builds the next variable-to-check message, in five steps:

1. It adds the channel LLR of each listed symbol to that couple's LLR.
2. It rebuilds the four most likely channel candidates and lifts each of them by the default offset.
3. It keeps the five cheapest of the `N_IN + 4` couples.
4. It removes repeated symbols, leaving four couples.
5. It shifts the LLRs so that the best couple costs zero.

The unit is fully pipelined. It accepts one message per clock, and each result leaves eight cycles after its input. A decoder places one instance beside each edge of a check-node datapath. `N_IN` is 16 or 20, depending on which check-node output feeds the instance.

Top module: `vnu_update_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 8 clock cycles. Synchronous reset clears every stage, so `out_valid` is 0 during reset and for 8 cycles after it.
- R2: Each incoming couple j gets the LLR `cv_llr[j] + E(cv_sym[j])` and keeps its symbol. E(x) is the sum of `int_mag[p]` over every bit p (bit p weighted by magnitude p) where x differs from `int_hard`.
- R3: Four candidates are rebuilt. Each one's LLR is lifted by `def_off`.
  - cand0 is (0, hard).
  - cand1 flips bit `int_pidx[0]` at cost `int_mag[int_pidx[0]]`.
  - cand2 flips bit `int_pidx[1]` at cost `int_mag[int_pidx[1]]`.
  - cand3 has two cases. Let A be the sum of the two weakest magnitudes and B the third weakest. If A <= B, cand3 flips both weakest bits at cost A. Otherwise it flips bit `int_pidx[2]` at cost B.
  - Each `int_pidx` entry is below 6, and the three entries are pairwise distinct.
- R4: The five couples with the lowest LLR are kept, in ascending order. Equal LLRs are ordered by position: incoming couples 0..N_IN-1 come first, then cand0..cand3.
- R5: Among the five kept couples, a couple is dropped when an earlier kept couple carries the same symbol. The first four survivors form the output in ascending LLR order, so the output symbols are pairwise distinct.
- R6: If fewer than four distinct symbols survive, the empty slots are filled in turn with the smallest symbol values (0, 1, 2, ...) not already present. Each filled slot has LLR 63 before normalization.
- R7: The first output couple has LLR zero and is not transmitted. `out_llr[k]` equals the LLR of couple k+1 minus the LLR of couple 0, so `out_llr` is non-decreasing.
- R8: Every LLR addition saturates at 63 and never wraps.
- R9: The output packs the four symbols as `out_sym[0..3]` (best first) and the three non-zero LLRs as `out_llr[0..2]`. Together these are 42 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input message present this cycle |
| cv_llr | input | N_IN x 6 | LLRs of the check-to-variable couples |
| cv_sym | input | N_IN x 6 | GF symbols of the check-to-variable couples |
| def_off | input | 6 | Default offset for unlisted symbols |
| int_mag | input | 6 x 5 | Channel magnitude per symbol bit |
| int_pidx | input | 3 x 3 | Positions of the weakest, second and third weakest bits |
| int_hard | input | 6 | Hard-decision symbol |
| out_valid | output | 1 | Output message present |
| out_sym | output | 4 x 6 | Output symbols, best first |
| out_llr | output | 3 x 6 | Normalized LLRs of symbols 1..3 |

## Verification
A wrong rank or a wrong tie order in the selector shows up as a wrong symbol or a wrong LLR difference in the very message that caused it, eight cycles after that message enters. A stale register in one stage shows up differently. It corrupts a single message in a back-to-back stream while its neighbours stay correct, so the stream is driven with gaps and with bursts. Several conditions are forced directly with crafted inputs:
- duplicates that leave too few distinct symbols, which exercises the fill path;
- additions that saturate at 63;
- runs of equal LLRs, which exercise the tie order.

// File: rtl/vnu_pkg.sv
package vnu_pkg;

    localparam int LLR_W  = 6;
    localparam int SYM_W  = 6;
    localparam int MAG_W  = 5;
    localparam int IDX_W  = 3;
    localparam int N_CAND = 4;
    localparam int N_KEEP = 5;
    localparam int N_OUT  = 4;
    localparam int N_WEAK = 3;
    localparam int N_TAIL = 3;          // pure delay stages after normalization
    localparam logic [LLR_W-1:0] LLR_MAX = '1;

    typedef logic [LLR_W-1:0] llr_t;
    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [SYM_W-1:0][MAG_W-1:0] mag_vec_t;
    typedef logic [N_WEAK-1:0][IDX_W-1:0] weak_vec_t;

    typedef struct packed {
        llr_t llr;
        sym_t sym;
    } couple_t;

    typedef struct packed {
        logic                  v;
        sym_t [N_OUT-1:0]      sym;
        llr_t [N_OUT-2:0]      llr;
    } result_t;

    function automatic llr_t sat_add(input llr_t a, input llr_t b);
        logic [LLR_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[LLR_W] ? LLR_MAX : s[LLR_W-1:0];
    endfunction

    function automatic logic [MAG_W-1:0] pick_mag(input mag_vec_t m, input logic [IDX_W-1:0] idx);
        logic [MAG_W-1:0] r;
        r = '0;
        for (int p = 0; p < SYM_W; p++)
            if (idx == IDX_W'(p)) r = m[p];
        return r;
    endfunction

    function automatic sym_t bit_mask(input logic [IDX_W-1:0] idx);
        sym_t r;
        r = '0;
        for (int p = 0; p < SYM_W; p++)
            if (idx == IDX_W'(p)) r[p] = 1'b1;
        return r;
    endfunction

    // channel cost of a symbol: magnitudes summed over bits that disagree with the hard decision
    function automatic llr_t chan_llr(input sym_t x, input sym_t hard, input mag_vec_t m);
        logic [LLR_W+2:0] s;
        sym_t d;
        d = x ^ hard;
        s = '0;
        for (int p = 0; p < SYM_W; p++)
            if (d[p]) s = s + (LLR_W+3)'(m[p]);
        return (s > (LLR_W+3)'(LLR_MAX)) ? LLR_MAX : s[LLR_W-1:0];
    endfunction

endpackage

// File: rtl/vnu_front.sv
module vnu_front
    import vnu_pkg::*;
#(
    parameter int N_IN = 16,
    localparam int N_TOT = N_IN + N_CAND
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  couple_t [N_IN-1:0]    cv,
    input  llr_t                  def_off,
    input  mag_vec_t              mag,
    input  weak_vec_t             pidx,
    input  sym_t                  hard,
    output logic                  v_q,
    output couple_t [N_TOT-1:0]   list_q
);

    couple_t [N_TOT-1:0] list_d;
    logic [MAG_W-1:0] m0, m1, m2;
    logic [MAG_W:0]   pair_cost;

    always_comb begin
        for (int j = 0; j < N_IN; j++) begin
            list_d[j].sym = cv[j].sym;
            list_d[j].llr = sat_add(cv[j].llr, chan_llr(cv[j].sym, hard, mag));
        end
        m0 = pick_mag(mag, pidx[0]);
        m1 = pick_mag(mag, pidx[1]);
        m2 = pick_mag(mag, pidx[2]);
        pair_cost = {1'b0, m0} + {1'b0, m1};
        list_d[N_IN]     = '{llr: def_off, sym: hard};
        list_d[N_IN + 1] = '{llr: sat_add(llr_t'(m0), def_off), sym: hard ^ bit_mask(pidx[0])};
        list_d[N_IN + 2] = '{llr: sat_add(llr_t'(m1), def_off), sym: hard ^ bit_mask(pidx[1])};
        if (pair_cost <= {1'b0, m2})
            list_d[N_IN + 3] = '{llr: sat_add(llr_t'(pair_cost), def_off),
                                 sym: hard ^ bit_mask(pidx[0]) ^ bit_mask(pidx[1])};
        else
            list_d[N_IN + 3] = '{llr: sat_add(llr_t'(m2), def_off), sym: hard ^ bit_mask(pidx[2])};
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= in_valid;
        list_q <= list_d;
    end

    // R3
    pidx_range_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (pidx[0] < 3'd6 && pidx[1] < 3'd6 && pidx[2] < 3'd6 &&
                      pidx[0] != pidx[1] && pidx[0] != pidx[2] && pidx[1] != pidx[2]));

    generate
        for (genvar g = 0; g < N_IN; g++) begin : g_wrap
            // R8
            no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> (list_q[g].llr >= $past(cv[g].llr)));
        end
    endgenerate

endmodule

// File: rtl/vnu_select.sv
module vnu_select
    import vnu_pkg::*;
#(
    parameter int N_TOT = 20,
    localparam int RW = $clog2(N_TOT + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   v_i,
    input  couple_t [N_TOT-1:0]    list_i,
    output logic                   v_q,
    output couple_t [N_KEEP-1:0]   keep_q
);

    logic [N_TOT-1:0][RW-1:0] rank_d, rank_q;
    couple_t [N_TOT-1:0]      list_r;
    logic                     v_r;
    couple_t [N_KEEP-1:0]     keep_d;

    // stage A: rank every couple (lower LLR first, lower position wins a tie)
    always_comb begin
        for (int i = 0; i < N_TOT; i++) begin
            rank_d[i] = '0;
            for (int j = 0; j < N_TOT; j++) begin
                if ((list_i[j].llr < list_i[i].llr) ||
                    ((list_i[j].llr == list_i[i].llr) && (j < i)))
                    rank_d[i] = rank_d[i] + RW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) v_r <= 1'b0;
        else     v_r <= v_i;
        rank_q <= rank_d;
        list_r <= list_i;
    end

    // stage B: route the couples ranked 0..4 to their slots
    always_comb begin
        for (int k = 0; k < N_KEEP; k++) begin
            keep_d[k] = '0;
            for (int i = 0; i < N_TOT; i++)
                if (rank_q[i] == RW'(k)) keep_d[k] = keep_d[k] | list_r[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_r;
        keep_q <= keep_d;
    end

    generate
        for (genvar g = 0; g + 1 < N_KEEP; g++) begin : g_ord
            // R4
            keep_order_chk: assert property (@(posedge clk) disable iff (rst)
                v_q |-> (keep_q[g].llr <= keep_q[g+1].llr));
        end
    endgenerate

endmodule

// File: rtl/vnu_dedup.sv
module vnu_dedup
    import vnu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  v_i,
    input  couple_t [N_KEEP-1:0]  keep_i,
    output result_t               res_q
);

    couple_t [N_OUT-1:0] uniq_d, uniq_q;
    logic                v_u;
    result_t             res_d;

    always_comb begin
        int  cnt;
        logic dup;
        logic used;
        uniq_d = '0;
        cnt = 0;
        for (int k = 0; k < N_KEEP; k++) begin
            dup = 1'b0;
            for (int e = 0; e < k; e++)
                if (keep_i[e].sym == keep_i[k].sym) dup = 1'b1;
            if (!dup && cnt < N_OUT) begin
                uniq_d[cnt] = keep_i[k];
                cnt = cnt + 1;
            end
        end
        // fill missing slots with the smallest absent symbol values
        for (int s = 0; s < 2 * N_OUT - 1; s++) begin
            used = 1'b0;
            for (int e = 0; e < N_OUT; e++)
                if (e < cnt && uniq_d[e].sym == SYM_W'(s)) used = 1'b1;
            if (!used && cnt < N_OUT) begin
                uniq_d[cnt] = '{llr: LLR_MAX, sym: SYM_W'(s)};
                cnt = cnt + 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) v_u <= 1'b0;
        else     v_u <= v_i;
        uniq_q <= uniq_d;
    end

    always_comb begin
        res_d.v = v_u;
        for (int k = 0; k < N_OUT; k++) res_d.sym[k] = uniq_q[k].sym;
        for (int k = 1; k < N_OUT; k++) res_d.llr[k-1] = uniq_q[k].llr - uniq_q[0].llr;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q.v <= 1'b0;
        else     res_q.v <= res_d.v;
        res_q.sym <= res_d.sym;
        res_q.llr <= res_d.llr;
    end

    // R5
    distinct_sym_chk: assert property (@(posedge clk) disable iff (rst)
        v_u |-> (uniq_q[0].sym != uniq_q[1].sym && uniq_q[0].sym != uniq_q[2].sym &&
                 uniq_q[0].sym != uniq_q[3].sym && uniq_q[1].sym != uniq_q[2].sym &&
                 uniq_q[1].sym != uniq_q[3].sym && uniq_q[2].sym != uniq_q[3].sym));

endmodule

// File: rtl/vnu_update_unit.sv
module vnu_update_unit
    import vnu_pkg::*;
#(
    parameter int N_IN = 16,
    localparam int N_TOT = N_IN + N_CAND,
    localparam int LAT = 5 + N_TAIL
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [N_IN-1:0][LLR_W-1:0]    cv_llr,
    input  logic [N_IN-1:0][SYM_W-1:0]    cv_sym,
    input  logic [LLR_W-1:0]              def_off,
    input  logic [SYM_W-1:0][MAG_W-1:0]   int_mag,
    input  logic [N_WEAK-1:0][IDX_W-1:0]  int_pidx,
    input  logic [SYM_W-1:0]              int_hard,
    output logic                          out_valid,
    output logic [N_OUT-1:0][SYM_W-1:0]   out_sym,
    output logic [N_OUT-2:0][LLR_W-1:0]   out_llr
);

    couple_t [N_IN-1:0]   cv;
    logic                 v1, v3;
    couple_t [N_TOT-1:0]  list1;
    couple_t [N_KEEP-1:0] keep3;
    result_t [N_TAIL:0]   tail;

    always_comb
        for (int j = 0; j < N_IN; j++) cv[j] = '{llr: cv_llr[j], sym: cv_sym[j]};

    vnu_front #(.N_IN(N_IN)) u_front (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cv(cv), .def_off(def_off),
        .mag(int_mag), .pidx(int_pidx), .hard(int_hard), .v_q(v1), .list_q(list1)
    );

    vnu_select #(.N_TOT(N_TOT)) u_select (
        .clk(clk), .rst(rst), .v_i(v1), .list_i(list1), .v_q(v3), .keep_q(keep3)
    );

    vnu_dedup u_dedup (
        .clk(clk), .rst(rst), .v_i(v3), .keep_i(keep3), .res_q(tail[0])
    );

    generate
        for (genvar g = 1; g <= N_TAIL; g++) begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) tail[g].v <= 1'b0;
                else     tail[g].v <= tail[g-1].v;
                tail[g].sym <= tail[g-1].sym;
                tail[g].llr <= tail[g-1].llr;
            end
        end
    endgenerate

    assign out_valid = tail[N_TAIL].v;
    assign out_sym   = tail[N_TAIL].sym;
    assign out_llr   = tail[N_TAIL].llr;

    logic [3:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                      since_rst <= '0;
        else if (since_rst < 4'(LAT)) since_rst <= since_rst + 4'd1;
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 4'(LAT)) |-> (out_valid == $past(in_valid, 8)));

    // R7
    norm_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_llr[0] <= out_llr[1] && out_llr[1] <= out_llr[2]));

endmodule

// File: tb/tb_vnu_update_unit.sv
module tb_vnu_update_unit;

    localparam int N = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [N-1:0][5:0] cv_llr = '0;
    logic [N-1:0][5:0] cv_sym = '0;
    logic [5:0] def_off = '0;
    logic [5:0][4:0] int_mag = '0;
    logic [2:0][2:0] int_pidx = '0;
    logic [5:0] int_hard = '0;
    logic out_valid;
    logic [3:0][5:0] out_sym;
    logic [2:0][5:0] out_llr;

    always #10 clk = ~clk;

    vnu_update_unit #(.N_IN(N)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cv_llr(cv_llr), .cv_sym(cv_sym),
        .def_off(def_off), .int_mag(int_mag), .int_pidx(int_pidx), .int_hard(int_hard),
        .out_valid(out_valid), .out_sym(out_sym), .out_llr(out_llr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int c_llr[N], c_sym[N], c_d, c_mag[6], c_p[3], c_hard;

    bit          q_v[$];
    logic [41:0] q_d[$];
    string       q_tag[$];

    function automatic int cost(int x, int h);
        int s = 0;
        for (int p = 0; p < 6; p++) if (((x ^ h) >> p) & 1) s += c_mag[p];
        return (s > 63) ? 63 : s;
    endfunction

    function automatic int sat(int a);
        return (a > 63) ? 63 : a;
    endfunction

    function automatic logic [41:0] model();
        int l[N+4], s[N+4];
        bit taken[N+4];
        int kl[5], ks[5], ul[4], us[4];
        int n, a, b, best;
        logic [3:0][5:0] es;
        logic [2:0][5:0] el;
        for (int j = 0; j < N; j++) begin
            l[j] = sat(c_llr[j] + cost(c_sym[j], c_hard));   // R2
            s[j] = c_sym[j];
        end
        l[N] = c_d;                              s[N] = c_hard;               // R3
        l[N+1] = sat(c_mag[c_p[0]] + c_d);       s[N+1] = c_hard ^ (1 << c_p[0]);
        l[N+2] = sat(c_mag[c_p[1]] + c_d);       s[N+2] = c_hard ^ (1 << c_p[1]);
        a = c_mag[c_p[0]] + c_mag[c_p[1]];
        b = c_mag[c_p[2]];
        if (a <= b) begin l[N+3] = sat(a + c_d); s[N+3] = c_hard ^ (1 << c_p[0]) ^ (1 << c_p[1]); end
        else        begin l[N+3] = sat(b + c_d); s[N+3] = c_hard ^ (1 << c_p[2]); end
        foreach (taken[i]) taken[i] = 0;
        for (int k = 0; k < 5; k++) begin                                    // R4
            best = -1;
            for (int i = 0; i < N + 4; i++)
                if (!taken[i] && (best < 0 || l[i] < l[best])) best = i;
            taken[best] = 1; kl[k] = l[best]; ks[k] = s[best];
        end
        n = 0;
        for (int k = 0; k < 5; k++) begin                                    // R5
            bit dup = 0;
            for (int e = 0; e < n; e++) if (us[e] == ks[k]) dup = 1;
            if (!dup && n < 4) begin ul[n] = kl[k]; us[n] = ks[k]; n++; end
        end
        for (int v = 0; v < 64 && n < 4; v++) begin                          // R6
            bit used = 0;
            for (int e = 0; e < n; e++) if (us[e] == v) used = 1;
            if (!used) begin ul[n] = 63; us[n] = v; n++; end
        end
        for (int k = 0; k < 4; k++) es[k] = 6'(us[k]);                      // R9
        for (int k = 1; k < 4; k++) el[k-1] = 6'(ul[k] - ul[0]);            // R7
        return {es, el};
    endfunction

    task automatic step(bit v, string tag);
        @(negedge clk);
        if (q_v.size() >= 8) begin
            bit ev = q_v.pop_front();
            logic [41:0] ed = q_d.pop_front();
            string et = q_tag.pop_front();
            checks++;
            if (out_valid !== ev) begin
                errors++;
                $display("FAIL R1 valid (%s): got %0b expected %0b", et, out_valid, ev);
            end else if (ev) begin
                checks++;
                if ({out_sym, out_llr} !== ed) begin
                    errors++;
                    $display("FAIL %s: got sym %h llr %h expected %h", et, out_sym, out_llr, ed);
                end
            end
        end
        in_valid = v;
        for (int j = 0; j < N; j++) begin cv_llr[j] = 6'(c_llr[j]); cv_sym[j] = 6'(c_sym[j]); end
        def_off = 6'(c_d);
        for (int p = 0; p < 6; p++) int_mag[p] = 5'(c_mag[p]);
        for (int p = 0; p < 3; p++) int_pidx[p] = 3'(c_p[p]);
        int_hard = 6'(c_hard);
        q_v.push_back(v);
        q_d.push_back(v ? model() : 42'd0);
        q_tag.push_back(tag);
    endtask

    task automatic rand_chan(int mag_max);
        int perm[6];
        for (int p = 0; p < 6; p++) begin perm[p] = p; c_mag[p] = $urandom_range(mag_max, 0); end
        for (int p = 5; p > 0; p--) begin
            int r = $urandom_range(p, 0);
            int t = perm[p]; perm[p] = perm[r]; perm[r] = t;
        end
        for (int p = 0; p < 3; p++) c_p[p] = perm[p];
        c_hard = $urandom_range(63, 0);
    endtask

    task automatic rand_cv(int llr_max);
        for (int j = 0; j < N; j++) begin
            c_llr[j] = $urandom_range(llr_max, 0);
            c_sym[j] = $urandom_range(63, 0);
        end
        c_d = $urandom_range(20, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rand_chan(31); rand_cv(63);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got %0b expected 0", out_valid);
        end
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 8; i++) begin q_v.push_back(0); q_d.push_back('0); q_tag.push_back("R1 post-reset"); end

        // R2 / R3: plain message with mixed costs
        rand_chan(15); rand_cv(40); step(1, "R2 R3 plain");
        rand_chan(31); rand_cv(10); step(1, "R2 R3 low cv");

        // R5: several couples repeat the hard symbol with zero cost
        rand_chan(31); c_d = 0;
        for (int j = 0; j < N; j++) begin c_llr[j] = 50; c_sym[j] = (j * 7) & 63; end
        for (int j = 0; j < 3; j++) begin c_llr[j] = 0; c_sym[j] = c_hard; end
        step(1, "R5 duplicate hard");

        // R6: five best are one symbol, fill with smallest absent values
        for (int p = 0; p < 6; p++) c_mag[p] = 31;
        c_p[0] = 0; c_p[1] = 1; c_p[2] = 2; c_hard = 9; c_d = 63;
        for (int j = 0; j < N; j++) begin c_llr[j] = 0; c_sym[j] = 9; end
        step(1, "R6 fill");
        for (int j = 0; j < N; j++) c_sym[j] = 1;
        c_hard = 1;
        step(1, "R6 fill skips 1");

        // R8: saturation everywhere
        for (int p = 0; p < 6; p++) c_mag[p] = 31;
        c_hard = 0; c_d = 60;
        for (int j = 0; j < N; j++) begin c_llr[j] = 60; c_sym[j] = 63 - j; end
        step(1, "R8 saturate");

        // R4: equal LLRs, order by position
        rand_chan(0); c_d = 5;
        for (int j = 0; j < N; j++) begin c_llr[j] = 5; c_sym[j] = c_hard ^ 0; end
        for (int j = 0; j < N; j++) c_sym[j] = j;
        c_hard = 0;
        step(1, "R4 ties");

        // R3: pair of weak bits against third weak bit, both branches
        rand_cv(63);
        for (int j = 0; j < N; j++) c_llr[j] = 63;
        c_mag = '{3, 4, 7, 20, 20, 20}; c_p = '{0, 1, 2}; c_hard = 12; c_d = 2;
        step(1, "R3 pair wins tie");
        c_mag = '{3, 4, 6, 20, 20, 20};
        step(1, "R3 third wins");

        // R1: gaps and bursts with random contents
        for (int i = 0; i < 400; i++) begin
            rand_chan(($urandom_range(1, 0) == 1) ? 31 : 8);
            rand_cv(($urandom_range(1, 0) == 1) ? 63 : 12);
            step($urandom_range(3, 0) != 0, "R9 random");
        end
        for (int i = 0; i < 10; i++) step(0, "R1 drain");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule